// File: doc/BRIEF.md
# Fractional-ratio clock divider

This block derives a slower clock from the system clock whose average period is a non-integer number of system cycles, I + N/D, with I, N and D supplied as unsigned run-time inputs. Because a counter only produces whole periods, each output period is either I or I+1 system cycles long. A signed error term chooses between the two lengths at every output edge. This keeps the edge-timing error bounded, and every D-th edge falls exactly where an ideal divider would place it.

A parameter selects one of two output shapes. In clock mode the output stays high for I/2 cycles (integer division) after each rising edge. In pulse mode it is a one-cycle strobe per period. An enable input starts and stops the divider, and the output rises on the first clock edge that samples the enable high. The ratio inputs are expected to stay constant while the divider runs. They may be changed while it is disabled.

Top module: `frac_div`

## Requirements
- R1: The sum of any D consecutive output periods, counted from the first edge after enabling, equals D*I+N system cycles, and every D-th edge lies exactly D*I+N cycles times its index after the first edge.
- R2: With N equal to 0, every output period is exactly I cycles, whatever the value of D.
- R3: The first period after enabling is always the short one, I cycles long.
- R4: With the error term E starting at 0 at the first edge, each period is I+1 cycles with D-N added to E if E < 0 at the edge that starts it. Otherwise it is I cycles with N subtracted from E.
- R5: For edge k after the first, the timing error D*t_k - k*(D*I+N) equals E and stays within -N <= E <= D-N-1. Here t_k is the cycle distance of edge k from the first edge.
- R6: While enable is 0 the output is 0 from the first clock edge that samples it low. After enable is raised, the output is 1 right after the next clock edge.
- R7: In clock mode (OUT_MODE = OUT_CLOCK) the output stays high for I/2 cycles (integer division) after every rising edge, with I at least 2.
- R8: In pulse mode (OUT_MODE = OUT_PULSE) the output is high for exactly one cycle per period.
- R9: Reset is asynchronous and active low. Asserting it forces the output to 0 at once. Its release is synchronised, so with enable held high the first output rise follows the third clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low holds the output at 0 and clears the divider |
| per_int | input | PERIOD_W | Integer part I of the ratio, in system cycles |
| frac_num | input | FRAC_W | Fraction numerator N, must be below frac_den |
| frac_den | input | FRAC_W | Fraction denominator D, ignored when frac_num is 0 |
| div_out | output | 1 | Divided clock or one-cycle pulse, chosen by OUT_MODE |

## Verification
A corrupted error term shows at the ports within one output period. The length of the next period then differs from the one the error-term model predicts, and the edge-position error, computed from the measured edge times, leaves its allowed range or fails to return to zero on the D-th edge. A wrong period counter shows as a period or a high phase of the wrong length at the next edge. A wrong enable or reset path shows as a misplaced first edge or a nonzero output in the cycle after enable falls. Random ratios, together with directed cases for N=0, N=D-1, I=2 and a large ratio, exercise both the long-period and the short-period decisions in both output modes.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;
  typedef enum logic {OUT_CLOCK = 1'b0, OUT_PULSE = 1'b1} out_mode_e;
endpackage

// File: rtl/frac_div_rst_sync.sv
`timescale 1ns/1ps
module frac_div_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/frac_div_err_acc.sv
`timescale 1ns/1ps
module frac_div_err_acc #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              long_o
);
  localparam int EW = FRAC_W + 1;

  logic signed [EW-1:0] err_q, err_d;
  logic signed [EW-1:0] num_s, den_s;

  assign num_s  = $signed({1'b0, num});
  assign den_s  = $signed({1'b0, den});
  assign long_o = err_q[EW-1];

  always_comb begin
    err_d = err_q;
    if (clr)
      err_d = '0;
    else if (step) begin
      if (long_o) err_d = err_q + den_s - num_s;
      else        err_d = err_q - num_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  // R5: error term bounded by -N .. D-N-1
  p_err_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (num < den) |-> ((err_q >= -num_s) && (err_q <= den_s - num_s - 1)));

  // R2: with N = 0 the error term never leaves zero
  p_zero_num_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (num == '0) && $stable(num) |=> (err_q == '0) || $changed(num));
endmodule

// File: rtl/frac_div_period_cnt.sv
`timescale 1ns/1ps
module frac_div_period_cnt #(
  parameter int PERIOD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] per_int,
  input  logic                long_i,
  output logic                fire_o
);
  logic                run_q, run_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;

  assign fire_o = en & (~run_q | (cnt_q == '0));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!en) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (fire_o) begin
      run_d = 1'b1;
      cnt_d = long_i ? per_int : per_int - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: the period started by the first edge is the short one
  p_first_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !run_q) |-> !long_i);

  // R1: a running count never exceeds the long-period load
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= per_int));
endmodule

// File: rtl/frac_div_shaper.sv
`timescale 1ns/1ps
module frac_div_shaper
  import frac_div_pkg::*;
#(
  parameter int        PERIOD_W = 12,
  parameter out_mode_e OUT_MODE = OUT_CLOCK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                fire,
  input  logic [PERIOD_W-1:0] per_int,
  output logic                out_o
);
  logic out_q, out_d;

  generate
    if (OUT_MODE == OUT_PULSE) begin : g_pulse
      assign out_d = fire;

      // R8: strobe lasts one cycle when periods are at least two cycles
      p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && (per_int >= 2) && $stable(per_int)) |=> !out_q);
    end else begin : g_clock
      localparam int PW = PERIOD_W;
      logic [PW-1:0] half;
      logic [PW-1:0] ph_q, ph_d;

      assign half = per_int >> 1;

      always_comb begin
        ph_d = ph_q;
        if (!en)        ph_d = '0;
        else if (fire)  ph_d = '0;
        else if (out_q) ph_d = ph_q + 1'b1;
      end

      assign out_d = fire | (en & out_q & ((ph_q + 1'b1) < half));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      // R7: high phase never runs past I/2 cycles
      p_high_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && $stable(per_int)) |-> (ph_q < half));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/frac_div.sv
`timescale 1ns/1ps
module frac_div
  import frac_div_pkg::*;
#(
  parameter int        PERIOD_W = 12,
  parameter int        FRAC_W   = 6,
  parameter out_mode_e OUT_MODE = OUT_CLOCK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] per_int,
  input  logic [FRAC_W-1:0]   frac_num,
  input  logic [FRAC_W-1:0]   frac_den,
  output logic                div_out
);
  logic rst_n_s;
  logic fire;
  logic long_sel;

  frac_div_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  frac_div_err_acc #(.FRAC_W(FRAC_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (~en),
    .step   (fire),
    .num    (frac_num),
    .den    (frac_den),
    .long_o (long_sel)
  );

  frac_div_period_cnt #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (en),
    .per_int (per_int),
    .long_i  (long_sel),
    .fire_o  (fire)
  );

  frac_div_shaper #(.PERIOD_W(PERIOD_W), .OUT_MODE(OUT_MODE)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (en),
    .fire    (fire),
    .per_int (per_int),
    .out_o   (div_out)
  );

  // R6: output is low in the cycle after enable is sampled low
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |=> !div_out);

  // R6: raising enable makes the output rise at the next edge
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en && !$past(en)) |-> ##0 1'b1 ##1 div_out);

  // R9: output is low whenever the synchronised reset is active
  p_reset_low_r9: assert property (@(posedge clk) !rst_n_s |-> !div_out);
endmodule

// File: tb/frac_div_test.sv
`timescale 1ns/1ps
module frac_div_test;
  import frac_div_pkg::*;

  localparam int PW = 12;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic [PW-1:0] per_int;
  logic [FW-1:0] frac_num, frac_den;
  logic o_c, o_p;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  frac_div #(.PERIOD_W(PW), .FRAC_W(FW), .OUT_MODE(OUT_CLOCK)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .per_int(per_int),
    .frac_num(frac_num), .frac_den(frac_den), .div_out(o_c));

  frac_div #(.PERIOD_W(PW), .FRAC_W(FW), .OUT_MODE(OUT_PULSE)) uut_pulse (
    .clk(clk), .rst_n(rst_n), .en(en), .per_int(per_int),
    .frac_num(frac_num), .frac_den(frac_den), .div_out(o_p));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_half(input int i);
    return i / 2;
  endfunction

  // Runs one ratio for nper periods and checks all edges against a model.
  task automatic run_case(input int ci, input int cn, input int cd, input int nper);
    int cyc, k, first, last_rise, e, expper, per, jit, limit;
    bit prev_c;
    en = 1'b0;
    @(negedge clk);
    chk(o_c == 1'b0 && o_p == 1'b0, "R6 low after enable drop", int'(o_c) + int'(o_p), 0);
    per_int = PW'(ci); frac_num = FW'(cn); frac_den = FW'(cd);
    repeat (3) @(negedge clk);
    chk(o_c == 1'b0 && o_p == 1'b0, "R6 idle output", int'(o_c) + int'(o_p), 0);
    en = 1'b1;
    cyc = 0; k = 0; first = 0; last_rise = 0; e = 0; prev_c = 1'b0;
    limit = (nper + 2) * (ci + 2);
    for (int s = 0; s < limit && k <= nper; s++) begin
      @(negedge clk);
      cyc++;
      if (o_c && !prev_c) begin
        if (k == 0) begin
          chk(cyc == 1, "R6 first rise", cyc, 1);
          first = cyc;
        end else begin
          if (e < 0) begin expper = ci + 1; e += cd - cn; end
          else       begin expper = ci;     e -= cn;      end
          per = cyc - last_rise;
          if (k == 1)       chk(per == ci, "R3 first period short", per, ci);
          else if (cn == 0) chk(per == ci, "R2 integer period", per, ci);
          else              chk(per == expper, "R4 period length", per, expper);
          jit = cd * (cyc - first) - k * (cd * ci + cn);
          chk(jit == e && jit >= -cn && jit <= cd - cn - 1, "R5 edge error", jit, e);
          if (k % cd == 0) chk(jit == 0, "R1 D-period sum", jit, 0);
        end
        chk(o_p == 1'b1, "R8 pulse at edge", int'(o_p), 1);
        last_rise = cyc;
        k++;
      end else if (cyc == last_rise + 1 && k > 0) begin
        chk(o_p == 1'b0, "R8 pulse one cycle", int'(o_p), 0);
      end
      if (!o_c && prev_c)
        chk(cyc - last_rise == exp_half(ci), "R7 high phase", cyc - last_rise, exp_half(ci));
      prev_c = o_c;
    end
    chk(k > nper, "R1 edge count", k, nper + 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int ri, rn, rd;
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b1;
    per_int = PW'(4); frac_num = FW'(1); frac_den = FW'(3);
    repeat (3) @(negedge clk);
    chk(o_c == 1'b0 && o_p == 1'b0, "R9 reset state", int'(o_c) + int'(o_p), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_c == 1'b0, "R9 release edge 1", int'(o_c), 0);
    @(negedge clk);
    chk(o_c == 1'b0, "R9 release edge 2", int'(o_c), 0);
    @(negedge clk);
    chk(o_c == 1'b1 && o_p == 1'b1, "R9 first rise after release", int'(o_c) + int'(o_p), 2);
    #1 rst_n = 1'b0;
    #1 chk(o_c == 1'b0 && o_p == 1'b0, "R9 async assert", int'(o_c) + int'(o_p), 0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b0;
    repeat (4) @(negedge clk);

    run_case(5, 2, 3, 8);
    run_case(7, 0, 5, 6);      // N = 0, D ignored
    run_case(2, 1, 2, 8);      // smallest clock-mode ratio
    run_case(9, 6, 7, 16);     // N = D-1, mostly long periods
    run_case(868, 1, 18, 38);  // large ratio
    for (int t = 0; t < 8; t++) begin
      ri = 2 + int'($urandom_range(38));
      rd = 2 + int'($urandom_range(18));
      rn = int'($urandom_range(rd - 1));
      run_case(ri, rn, rd, 2 * rd + 3);
    end
    en = 1'b0;
    @(negedge clk);
    chk(o_c == 1'b0 && o_p == 1'b0, "R6 final drop", int'(o_c) + int'(o_p), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule